// File: doc/BRIEF.md
# Paired-Channel PWM Generator with Clock Bypass

This block produces six pulse-width-modulated outputs arranged as three pairs. Each pair picks one of two source tick streams, gates it and divides it by a power of two. Both channels of the pair share that divided tick. Each channel then divides the shared tick again by its own power of two. The result drives a counter that compares against a programmed period and active count. The source streams arrive as single-cycle clock enables in the block's own clock domain, one per source.

A channel can instead be put in bypass. In bypass its output copies the pair's shared tick, one cycle later, as a plain pulse train. The channel's own divider and its period and active-count logic play no part. This lets a channel serve as a divided clock output where the exact rate matters more than the duty cycle. Software programs the block through a write-only register port. Period and active-count changes are held back until the running period ends, so no pulse is ever cut short.

Top module: `pwm_pair_bank`

## Requirements
- R1: Channel c (0..5) belongs to pair c/2. Channel registers sit at address 4*c + field: field 0 is the period, field 1 is the active count, field 2 is the channel control. Pair p's control register sits at address 24 + p. A write to one channel or pair leaves every other channel's output unchanged.
- R2: Pair control bit 0 selects the source. A value of 0 takes `src_en_a` and a value of 1 takes `src_en_b`. The shared pair tick fires only in cycles where the selected enable is high.
- R3: Pair control bit 1 is the pair gate. While it is 0, both outputs of the pair stay low one cycle later, in PWM mode and in bypass.
- R4: Pair control bits 4:2 hold an exponent m. The shared tick passes every 2^m-th selected source enable, and m = 0 passes every enable.
- R5: Channel control bits 3:1 hold an exponent k. The channel's counter advances on every 2^k-th shared pair tick. This second divider receives no ticks while the channel is in bypass.
- R6: In PWM mode, each period of P counter ticks puts out A ticks high followed by P-A ticks low. An active count of 0 gives a constant low, and an active count of P or more gives a constant high.
- R7: A new period or active count takes effect only at the end of the period that is running. A pulse in progress keeps its old length.
- R8: Channel control bit 0 enables bypass. When the pair gate is on, the output is then high in exactly the cycles that follow a shared pair tick, whatever the channel's k, period and active count.
- R9: After reset all registers are zero, so every gate is off and every output is low until software programs the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en_a | input | 1 | Tick enable of source A |
| src_en_b | input | 1 | Tick enable of source B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | Channel outputs, bit c is channel c |

## Verification
The two sources run at different fixed rates: A ticks every second cycle and B every fifth cycle. A high-cycle count over a whole number of periods therefore shows which source, which pair divider and which channel divider set the output rate. Active counts of 0, 1, half, exactly the period and above the period cover the clamping at both ends of R6. In bypass the pulse count is taken for each source select and with a pair divider added. This tells a correct bypass apart from one that leaks through the channel divider or the duty compare. A mid-pulse rewrite of the active count, with both the current and the next high run measured, covers the deferred update. A gated-off pair is checked while its neighbour keeps running.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

   // field codes in address bits [1:0] of a channel slot
   localparam logic [1:0] FLD_PERIOD = 2'd0;
   localparam logic [1:0] FLD_ACTIVE = 2'd1;
   localparam logic [1:0] FLD_CTRL   = 2'd2;

   // channel control bit positions
   localparam int CH_BYP_BIT  = 0;
   localparam int CH_KEXP_LSB = 1;

   // pair control bit positions
   localparam int PR_SEL_BIT  = 0;
   localparam int PR_GATE_BIT = 1;
   localparam int PR_MEXP_LSB = 2;

   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } src_sel_e;

endpackage

// File: rtl/pwm_pow2_div.sv
module pwm_pow2_div #(
   parameter int EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);
   localparam int DIV_W = (1 << EXP_W) - 1;

   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("pwm_pow2_div: EXP_W must lie in 1..5");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      mask   = DIV_W'((32'd1 << exp_i) - 32'd1);
      tick_o = tick_i && ((cnt_q & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CNT_W = 16,
   parameter int EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pair_tick_i,
   input  logic             gate_i,
   input  logic             bypass_i,
   input  logic [EXP_W-1:0] k_exp_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] active_i,
   output logic             chan_tick_o,
   output logic             out_o
);
   logic             div_in;
   logic [CNT_W-1:0] cnt_q, per_q, act_q;
   logic [CNT_W:0]   cnt_nxt;
   logic             wrap;
   logic             level;

   // the second divider sees nothing while bypassed
   assign div_in = pair_tick_i & ~bypass_i;

   pwm_pow2_div #(.EXP_W(EXP_W)) u_kdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (div_in),
      .exp_i  (k_exp_i),
      .tick_o (chan_tick_o)
   );

   always_comb begin
      cnt_nxt = {1'b0, cnt_q} + 1'b1;
      wrap    = cnt_nxt >= {1'b0, per_q};
      level   = cnt_q < act_q;
   end

   // shadow copies reload only at the period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         act_q <= '0;
      end else if (chan_tick_o) begin
         if (wrap) begin
            cnt_q <= '0;
            per_q <= period_i;
            act_q <= active_i;
         end else begin
            cnt_q <= cnt_nxt[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_o <= 1'b0;
      else if (!gate_i)
         out_o <= 1'b0;
      else if (bypass_i)
         out_o <= pair_tick_i;
      else
         out_o <= level;
   end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
   import pwm_pair_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int EXP_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       src_en_a,
   input  logic                       src_en_b,
   input  src_sel_e                   sel_i,
   input  logic                       gate_i,
   input  logic [EXP_W-1:0]           m_exp_i,
   input  logic [1:0]                 bypass_i,
   input  logic [1:0][EXP_W-1:0]      k_exp_i,
   input  logic [1:0][CNT_W-1:0]      period_i,
   input  logic [1:0][CNT_W-1:0]      active_i,
   output logic                       pair_tick_o,
   output logic [1:0]                 chan_tick_o,
   output logic [1:0]                 out_o
);
   logic src_tick;
   logic gated_tick;

   always_comb begin
      unique case (sel_i)
         SRC_A:   src_tick = src_en_a;
         SRC_B:   src_tick = src_en_b;
         default: src_tick = 1'b0;
      endcase
      gated_tick = src_tick & gate_i;
   end

   pwm_pow2_div #(.EXP_W(EXP_W)) u_mdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (gated_tick),
      .exp_i  (m_exp_i),
      .tick_o (pair_tick_o)
   );

   for (genvar j = 0; j < 2; j++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .pair_tick_i (pair_tick_o),
         .gate_i      (gate_i),
         .bypass_i    (bypass_i[j]),
         .k_exp_i     (k_exp_i[j]),
         .period_i    (period_i[j]),
         .active_i    (active_i[j]),
         .chan_tick_o (chan_tick_o[j]),
         .out_o       (out_o[j])
      );
   end
endmodule

// File: rtl/pwm_pair_bank.sv
module pwm_pair_bank
   import pwm_pair_pkg::*;
#(
   parameter int NUM_PAIRS = 3,
   parameter int CNT_W     = 16,
   parameter int EXP_W     = 3,
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     src_en_a,
   input  logic                     src_en_b,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [2*NUM_PAIRS-1:0]   pwm_out
);
   localparam int NUM_CH    = 2 * NUM_PAIRS;
   localparam int PAIR_BASE = 4 * NUM_CH;
   localparam int SLOT_W    = ADDR_W - 2;

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("pwm_pair_bank: NUM_PAIRS must be at least 1");
   end
   if (PAIR_BASE + NUM_PAIRS > (1 << ADDR_W)) begin : g_bad_addr
      $error("pwm_pair_bank: ADDR_W too small for the register map");
   end
   if (DATA_W < CNT_W || DATA_W < PR_MEXP_LSB + EXP_W) begin : g_bad_data
      $error("pwm_pair_bank: DATA_W too narrow for its fields");
   end

   logic [NUM_PAIRS-1:0]             pair_sel_q;
   logic [NUM_PAIRS-1:0]             pair_gate_q;
   logic [NUM_PAIRS-1:0][EXP_W-1:0]  pair_mexp_q;
   logic [NUM_CH-1:0]                chan_byp_q;
   logic [NUM_CH-1:0][EXP_W-1:0]     chan_kexp_q;
   logic [NUM_CH-1:0][CNT_W-1:0]     chan_per_q;
   logic [NUM_CH-1:0][CNT_W-1:0]     chan_act_q;
   logic [NUM_PAIRS-1:0]             pair_tick;
   logic [NUM_CH-1:0]                chan_tick;

   logic [SLOT_W-1:0] slot;
   logic [1:0]        field;
   logic              unused_data;

   assign slot        = wr_addr[ADDR_W-1:2];
   assign field       = wr_addr[1:0];
   assign unused_data = ^wr_data;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chreg
      logic hit;
      assign hit = wr_en && (slot == SLOT_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chan_per_q[c]  <= '0;
            chan_act_q[c]  <= '0;
            chan_byp_q[c]  <= 1'b0;
            chan_kexp_q[c] <= '0;
         end else if (hit) begin
            case (field)
               FLD_PERIOD: chan_per_q[c] <= wr_data[CNT_W-1:0];
               FLD_ACTIVE: chan_act_q[c] <= wr_data[CNT_W-1:0];
               FLD_CTRL: begin
                  chan_byp_q[c]  <= wr_data[CH_BYP_BIT];
                  chan_kexp_q[c] <= wr_data[CH_KEXP_LSB +: EXP_W];
               end
               default: ;
            endcase
         end
      end
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(PAIR_BASE + p));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pair_sel_q[p]  <= 1'b0;
            pair_gate_q[p] <= 1'b0;
            pair_mexp_q[p] <= '0;
         end else if (hit) begin
            pair_sel_q[p]  <= wr_data[PR_SEL_BIT];
            pair_gate_q[p] <= wr_data[PR_GATE_BIT];
            pair_mexp_q[p] <= wr_data[PR_MEXP_LSB +: EXP_W];
         end
      end

      pwm_pair #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_pair (
         .clk         (clk),
         .rst_n       (rst_n),
         .src_en_a    (src_en_a),
         .src_en_b    (src_en_b),
         .sel_i       (src_sel_e'(pair_sel_q[p])),
         .gate_i      (pair_gate_q[p]),
         .m_exp_i     (pair_mexp_q[p]),
         .bypass_i    (chan_byp_q[2*p+1 -: 2]),
         .k_exp_i     (chan_kexp_q[2*p+1 -: 2]),
         .period_i    (chan_per_q[2*p+1 -: 2]),
         .active_i    (chan_act_q[2*p+1 -: 2]),
         .pair_tick_o (pair_tick[p]),
         .chan_tick_o (chan_tick[2*p+1 -: 2]),
         .out_o       (pwm_out[2*p+1 -: 2])
      );
   end
endmodule

// File: rtl/pwm_pair_bank_chk.sv
module pwm_pair_bank_chk #(
   parameter int NUM_PAIRS = 3,
   parameter int EXP_W     = 3
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            src_en_a,
   input logic                            src_en_b,
   input logic [2*NUM_PAIRS-1:0]          pwm_out,
   input logic [NUM_PAIRS-1:0]            pair_sel,
   input logic [NUM_PAIRS-1:0]            pair_gate,
   input logic [NUM_PAIRS-1:0][EXP_W-1:0] pair_mexp,
   input logic [2*NUM_PAIRS-1:0]          chan_byp,
   input logic [NUM_PAIRS-1:0]            pair_tick,
   input logic [2*NUM_PAIRS-1:0]          chan_tick
);
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_p
      // R2: shared tick only with the selected source and the gate on
      assert_tick_from_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
         pair_tick[p] |-> (pair_gate[p] && (pair_sel[p] ? src_en_b : src_en_a)));

      // R3: a closed gate silences both outputs of the pair
      assert_gate_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!pair_gate[p]) |-> (pwm_out[2*p+1 -: 2] == 2'b00));

      for (genvar j = 0; j < 2; j++) begin : g_c
         // R5: channel divider only advances on a pair tick outside bypass
         assert_k_follows_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
            chan_tick[2*p+j] |-> (pair_tick[p] && !chan_byp[2*p+j]));

         // R8: undivided bypass output copies the selected enable one cycle late
         assert_bypass_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(chan_byp[2*p+j] && pair_gate[p] && (pair_mexp[p] == '0))
            |-> (pwm_out[2*p+j] == $past(pair_sel[p] ? src_en_b : src_en_a)));
      end
   end
endmodule

bind pwm_pair_bank pwm_pair_bank_chk #(
   .NUM_PAIRS (NUM_PAIRS),
   .EXP_W     (EXP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_en_a  (src_en_a),
   .src_en_b  (src_en_b),
   .pwm_out   (pwm_out),
   .pair_sel  (pair_sel_q),
   .pair_gate (pair_gate_q),
   .pair_mexp (pair_mexp_q),
   .chan_byp  (chan_byp_q),
   .pair_tick (pair_tick),
   .chan_tick (chan_tick)
);

// File: tb/pwm_pair_bank_bench.sv
module pwm_pair_bank_bench;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_en_a = 1'b0;
   logic        src_en_b = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [5:0]  pwm_out;

   int total = 0;
   int bad = 0;
   int pa = 0;
   int pb = 0;

   typedef struct {
      string tag;
      int    ch;
      int    window;
      int    exp_high;
   } item_t;
   item_t sbq[$];

   pwm_pair_bank u_pwm_pair_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_en_a (src_en_a),
      .src_en_b (src_en_b),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pwm_out  (pwm_out)
   );

   always #(CLK_NS/2) clk = ~clk;

   // source A ticks every 2nd cycle, source B every 5th
   initial begin
      forever begin
         @(negedge clk);
         pa = (pa + 1) % 2;
         pb = (pb + 1) % 5;
         src_en_a = (pa == 0);
         src_en_b = (pb == 0);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_reg(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 5'(addr);
      wr_data = 16'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver side of the scoreboard
   task automatic expect_high(input string tag, input int ch, input int win, input int exp);
      item_t it;
      it.tag = tag; it.ch = ch; it.window = win; it.exp_high = exp;
      sbq.push_back(it);
      wait (sbq.size() == 0);
   endtask

   // monitor side: counts high cycles over the requested window
   initial begin
      item_t it;
      int hc;
      forever begin
         wait (sbq.size() > 0);
         it = sbq[0];
         hc = 0;
         repeat (it.window) begin
            @(negedge clk);
            if (pwm_out[it.ch]) hc++;
         end
         check(it.tag, hc, it.exp_high);
         void'(sbq.pop_front());
      end
   end

   task automatic high_run(input int ch, output int run);
      do @(negedge clk); while (pwm_out[ch]);
      do @(negedge clk); while (!pwm_out[ch]);
      run = 1;
      @(negedge clk);
      while (pwm_out[ch]) begin
         run++;
         @(negedge clk);
      end
   endtask

   initial begin
      int run;
      settle(5);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 outputs low after reset", int'(pwm_out), 0);
      settle(50);
      check("R9 outputs stay low unprogrammed", int'(pwm_out), 0);

      // pair0: source A, gate on, m=0; ch0 period 4
      write_reg(24, 2);
      write_reg(0, 4);
      write_reg(1, 2);
      write_reg(2, 0);
      settle(40);
      expect_high("R6 active 2 of 4", 0, 80, 40);
      write_reg(1, 0);
      settle(40);
      expect_high("R6 active 0 constant low", 0, 80, 0);
      write_reg(1, 4);
      settle(40);
      expect_high("R6 active equals period constant high", 0, 80, 80);
      write_reg(1, 1);
      settle(40);
      expect_high("R6 active 1 of 4", 0, 80, 20);
      write_reg(1, 7);
      settle(40);
      expect_high("R6 active above period constant high", 0, 80, 80);
      write_reg(1, 1);

      // ch1: k=2 (divide by 4), period 4 active 1
      write_reg(4, 4);
      write_reg(5, 1);
      write_reg(6, 2 << 1);
      settle(200);
      expect_high("R5 channel divider by 4", 1, 320, 80);

      // pair0 m=1: both channels slow down by two
      write_reg(24, (1 << 2) | 2);
      settle(300);
      expect_high("R4 pair divider on ch0", 0, 160, 40);
      expect_high("R4 pair divider on ch1", 1, 640, 160);

      // pair1 bypass on ch3 with k=3 and active 0
      write_reg(25, 2);
      write_reg(13, 0);
      write_reg(14, 1 | (3 << 1));
      settle(20);
      expect_high("R8 bypass source A", 3, 200, 100);
      write_reg(25, 3);
      settle(20);
      expect_high("R2 bypass source B", 3, 200, 40);
      write_reg(25, (1 << 2) | 3);
      settle(40);
      expect_high("R4 bypass source B with m=1", 3, 200, 20);

      // gate pair1 off: bypass ch3 and constant-high ch2 both silent
      write_reg(8, 4);
      write_reg(9, 8);
      write_reg(10, 0);
      write_reg(25, 1);
      settle(5);
      expect_high("R3 gate off bypass channel", 3, 200, 0);
      expect_high("R3 gate off PWM channel", 2, 200, 0);
      expect_high("R1 pair0 unaffected by pair1", 0, 160, 40);

      // pair2 only via its own addresses
      write_reg(20, 2);
      write_reg(21, 1);
      write_reg(26, 2);
      settle(40);
      expect_high("R1 ch5 mapped at slot 5", 5, 40, 20);
      expect_high("R1 ch4 untouched stays low", 4, 40, 0);

      // deferred update: change active count in the middle of a pulse
      write_reg(8, 8);
      write_reg(9, 4);
      write_reg(25, 2);
      settle(60);
      fork
         high_run(2, run);
         begin
            do @(negedge clk); while (pwm_out[2]);
            do @(negedge clk); while (!pwm_out[2]);
            write_reg(9, 6);
         end
      join
      check("R7 running pulse keeps old length", run, 8);
      high_run(2, run);
      check("R7 next pulse uses new active count", run, 12);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule